// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous serial line into parallel characters. It works in a single system clock domain. A strobe input, `rx_tick`, marks each rising edge of the receive bit clock, and the block samples the serial line only on those strobes. Before use, the line passes through a short synchronizer. The oversampling factor can be 1, 16 or 64 strobes per bit. A character carries 5 to 8 data bits, least significant bit first, and may have an even or odd parity bit.

When a character completes, it is placed in a holding register and a ready flag rises. The host reads the character and pulses `data_ack` to clear the flag. Parity, framing and overrun problems set sticky flags, and only a pulse on `err_clear` clears them. A separate monitor counts how long the line has stayed low. It raises `break_det` once the low time covers two full character frames at the programmed format.

Top module: `serial_async_rx`

## Requirements
- R1: After reset, after re-enable, or after a frame whose stop bit was low, the receiver must first sample the line high before it accepts a low sample as a start bit.
- R2: `baud_sel` sets F, the strobes per bit: 2'b01 gives 1, 2'b10 gives 16, 2'b11 gives 64, and 2'b00 behaves as 1. Let the start be seen on strobe t0 and let H be F/2 (0 at 1x). Data bit i is then sampled on strobe t0+H+F*(i+1), and the parity and stop bits follow at the same spacing.
- R3: At 16x and 64x the line is sampled again on strobe t0+H. If it is high, the start is dropped, no character is produced, and the receiver waits for a new falling edge.
- R4: `len_sel` 2'b00..2'b11 selects 5..8 data bits. Data bit 0 lands in `rx_data[0]`, and bits above the character length read as zero.
- R5: With `parity_en` set, the bit after the data is a parity bit. `parity_even`=1 requires an even count of ones over data plus parity, and 0 requires an odd count. A mismatch sets `parity_err`.
- R6: Only one stop bit is sampled, whatever `stop_sel` is. A low stop sample sets `framing_err`, and the character is still delivered.
- R7: `rx_ready` rises when a character is loaded into `rx_data`. A `data_ack` pulse clears it.
- R8: If a character completes while `rx_ready` is still set and no `data_ack` arrives in the same cycle, the new character replaces the old one and `overrun_err` is set.
- R9: The three error flags are sticky. A set outranks an `err_clear` in the same cycle, and a set error never stops reception.
- R10: `break_det` rises on the strobe that makes the count of consecutive low samples equal to F times the frame length in half bits. The frame length in half bits is 2*(1+data bits+parity bit) plus 2, 3 or 4 for `stop_sel` 2'b01, 2'b10 or 2'b11 (2'b00 counts as 2).
- R11: One strobe that samples the line high clears `break_det` and restarts the low-time count.
- R12: While `rx_enable` is low, the line is ignored. Any frame in progress is dropped and `break_det` is cleared. `rx_data` and `rx_ready` keep their values.
- R13: Reset clears `rx_data`, `rx_ready`, all error flags and `break_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | One-cycle strobe per receive bit clock edge |
| rx_line | input | 1 | Serial input line, idle high |
| rx_enable | input | 1 | Receiver enable |
| baud_sel | input | 2 | Oversampling factor select |
| len_sel | input | 2 | Character length select (5 to 8 bits) |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | Even (1) or odd (0) parity |
| stop_sel | input | 2 | Programmed stop length, used only for break timing |
| data_ack | input | 1 | Host has read the character |
| err_clear | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Received character, zero-extended |
| rx_ready | output | 1 | Character waiting to be read |
| parity_err | output | 1 | Sticky parity error |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |
| break_det | output | 1 | Line held low for two frames |

## Verification
The hardest situations to reach from the ports are the exact strobe on which `break_det` rises and a start bit that fails its mid-bit check. The bench aligns every line change to the strobe grid and holds the line low for a counted number of strobes. It checks `break_det` one strobe before the limit and again on the limit, at two formats that give different limits. For the false start, the line is pulled low for fewer strobes than half a bit. The bench then confirms that nothing was delivered and that the next clean frame is still received correctly.

// File: rtl/rx_async_pkg.sv
package rx_async_pkg;

  // Geometry of the receiver
  localparam int RX_CHAR_MIN = 5;
  localparam int RX_CHAR_MAX = 8;
  localparam int RX_OVS_MID  = 16;
  localparam int RX_OVS_MAX  = 64;

  // Derived widths
  localparam int RX_TICK_W   = $clog2(RX_OVS_MAX);
  localparam int RX_IDX_W    = $clog2(RX_CHAR_MAX);
  localparam int RX_HALF_MAX = 2 * (RX_CHAR_MAX + 2) + 4;
  localparam int RX_BRK_W    = $clog2(RX_HALF_MAX * RX_OVS_MAX + 1);

  // Oversampling select codes
  localparam logic [1:0] OVS_X1  = 2'b01;
  localparam logic [1:0] OVS_X16 = 2'b10;
  localparam logic [1:0] OVS_X64 = 2'b11;

  typedef enum logic [2:0] {
    ST_ARM,
    ST_IDLE,
    ST_VERIFY,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic                 oversampled;
    logic [RX_TICK_W-1:0] bit_m1;
    logic [RX_TICK_W-1:0] half_m1;
    logic [RX_IDX_W-1:0]  last_idx;
    logic                 par_en;
    logic                 par_even;
    logic [RX_BRK_W-1:0]  brk_limit;
  } rx_cfg_t;

endpackage

// File: rtl/rx_mode_decode.sv
module rx_mode_decode
  import rx_async_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] baud_sel,
  input  logic [1:0] len_sel,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic [1:0] stop_sel,
  output rx_cfg_t    cfg
);

  rx_cfg_t cfg_d;

  always_comb begin
    int ticks;
    int nbits;
    int stop_halves;
    int halves;

    unique case (baud_sel)
      OVS_X16: ticks = RX_OVS_MID;
      OVS_X64: ticks = RX_OVS_MAX;
      default: ticks = 1;
    endcase

    nbits = RX_CHAR_MIN + int'(len_sel);

    unique case (stop_sel)
      2'b10:   stop_halves = 3;
      2'b11:   stop_halves = 4;
      default: stop_halves = 2;
    endcase

    halves = 2 * (1 + nbits + int'(parity_en)) + stop_halves;

    cfg_d.oversampled = (ticks > 1);
    cfg_d.bit_m1      = RX_TICK_W'(ticks - 1);
    cfg_d.half_m1     = (ticks > 1) ? RX_TICK_W'(ticks / 2 - 1) : '0;
    cfg_d.last_idx    = RX_IDX_W'(nbits - 1);
    cfg_d.par_en      = parity_en;
    cfg_d.par_even    = parity_even;
    cfg_d.brk_limit   = RX_BRK_W'(halves * ticks);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      cfg <= cfg_d;
    end
  end

endmodule

// File: rtl/rx_frame_sm.sv
module rx_frame_sm
  import rx_async_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   line,
  input  logic                   enable,
  input  rx_cfg_t                cfg,
  output logic                   done,
  output logic                   ferr_set,
  output logic                   perr_set,
  output logic [RX_CHAR_MAX-1:0] word
);

  rx_state_e            state;
  logic [RX_TICK_W-1:0] cnt;
  logic [RX_IDX_W-1:0]  idx;
  logic                 par_acc;
  logic                 expire;

  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state    <= ST_ARM;
      cnt      <= '0;
      idx      <= '0;
      par_acc  <= 1'b0;
      word     <= '0;
      done     <= 1'b0;
      ferr_set <= 1'b0;
      perr_set <= 1'b0;
    end else begin
      done     <= 1'b0;
      ferr_set <= 1'b0;
      perr_set <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_ARM: begin
            if (line) state <= ST_IDLE;
          end
          ST_IDLE: begin
            if (!line) begin
              word    <= '0;
              idx     <= '0;
              par_acc <= 1'b0;
              if (cfg.oversampled) begin
                state <= ST_VERIFY;
                cnt   <= cfg.half_m1;
              end else begin
                state <= ST_DATA;
                cnt   <= '0;
              end
            end
          end
          ST_VERIFY: begin
            if (!expire) begin
              cnt <= cnt - 1'b1;
            end else if (line) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_DATA;
              cnt   <= cfg.bit_m1;
            end
          end
          ST_DATA: begin
            if (!expire) begin
              cnt <= cnt - 1'b1;
            end else begin
              word[idx] <= line;
              par_acc   <= par_acc ^ line;
              cnt       <= cfg.bit_m1;
              if (idx == cfg.last_idx) begin
                state <= cfg.par_en ? ST_PARITY : ST_STOP;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
          ST_PARITY: begin
            if (!expire) begin
              cnt <= cnt - 1'b1;
            end else begin
              perr_set <= ((par_acc ^ line) == cfg.par_even);
              cnt      <= cfg.bit_m1;
              state    <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (!expire) begin
              cnt <= cnt - 1'b1;
            end else begin
              done     <= 1'b1;
              ferr_set <= ~line;
              state    <= line ? ST_IDLE : ST_ARM;
            end
          end
          default: state <= ST_ARM;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_break_mon.sv
module rx_break_mon
  import rx_async_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                line,
  input  logic                enable,
  input  logic [RX_BRK_W-1:0] limit,
  output logic                brk
);

  logic [RX_BRK_W-1:0] low_cnt;
  logic [RX_BRK_W:0]   low_next;

  assign low_next = {1'b0, low_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      low_cnt <= '0;
      brk     <= 1'b0;
    end else if (tick) begin
      if (line) begin
        low_cnt <= '0;
        brk     <= 1'b0;
      end else begin
        if (low_cnt < limit) low_cnt <= low_next[RX_BRK_W-1:0];
        if (low_next >= {1'b0, limit}) brk <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import rx_async_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   done,
  input  logic                   ferr_set,
  input  logic                   perr_set,
  input  logic [RX_CHAR_MAX-1:0] word,
  input  logic                   data_ack,
  input  logic                   err_clear,
  output logic [RX_CHAR_MAX-1:0] rx_data,
  output logic                   rx_ready,
  output logic                   parity_err,
  output logic                   framing_err,
  output logic                   overrun_err
);

  logic lost;

  assign lost = done & rx_ready & ~data_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      if (done) begin
        rx_data  <= word;
        rx_ready <= 1'b1;
      end else if (data_ack) begin
        rx_ready <= 1'b0;
      end
      parity_err  <= (parity_err  & ~err_clear) | perr_set;
      framing_err <= (framing_err & ~err_clear) | (done & ferr_set);
      overrun_err <= (overrun_err & ~err_clear) | lost;
    end
  end

endmodule

// File: rtl/serial_async_rx.sv
module serial_async_rx
  import rx_async_pkg::*;
#(
  parameter int DATA_W      = RX_CHAR_MAX,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_tick,
  input  logic              rx_line,
  input  logic              rx_enable,
  input  logic [1:0]        baud_sel,
  input  logic [1:0]        len_sel,
  input  logic              parity_en,
  input  logic              parity_even,
  input  logic [1:0]        stop_sel,
  input  logic              data_ack,
  input  logic              err_clear,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              parity_err,
  output logic              framing_err,
  output logic              overrun_err,
  output logic              break_det
);

  logic                   line_s;
  rx_cfg_t                cfg;
  logic                   frame_done;
  logic                   ferr_set;
  logic                   perr_set;
  logic [RX_CHAR_MAX-1:0] frame_word;
  logic [RX_CHAR_MAX-1:0] held_word;

  // Line synchronizer, idle-high on reset
  if (SYNC_STAGES == 0) begin : g_nosync
    assign line_s = rx_line;
  end else begin : g_sync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= '1;
      end else begin
        pipe[0] <= rx_line;
        for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      end
    end
    assign line_s = pipe[SYNC_STAGES-1];
  end

  rx_mode_decode u_decode (
    .clk         (clk),
    .rst         (rst),
    .baud_sel    (baud_sel),
    .len_sel     (len_sel),
    .parity_en   (parity_en),
    .parity_even (parity_even),
    .stop_sel    (stop_sel),
    .cfg         (cfg)
  );

  rx_frame_sm u_frame (
    .clk      (clk),
    .rst      (rst),
    .tick     (rx_tick),
    .line     (line_s),
    .enable   (rx_enable),
    .cfg      (cfg),
    .done     (frame_done),
    .ferr_set (ferr_set),
    .perr_set (perr_set),
    .word     (frame_word)
  );

  rx_break_mon u_break (
    .clk    (clk),
    .rst    (rst),
    .tick   (rx_tick),
    .line   (line_s),
    .enable (rx_enable),
    .limit  (cfg.brk_limit),
    .brk    (break_det)
  );

  rx_status_regs u_status (
    .clk         (clk),
    .rst         (rst),
    .done        (frame_done),
    .ferr_set    (ferr_set),
    .perr_set    (perr_set),
    .word        (frame_word),
    .data_ack    (data_ack),
    .err_clear   (err_clear),
    .rx_data     (held_word),
    .rx_ready    (rx_ready),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .overrun_err (overrun_err)
  );

  // Port width adaptation
  if (DATA_W >= RX_CHAR_MAX) begin : g_wide
    assign rx_data = DATA_W'(held_word);
  end else begin : g_narrow
    assign rx_data = held_word[DATA_W-1:0];
  end

endmodule

// File: rtl/rx_async_checker.sv
module rx_async_checker (
  input logic clk,
  input logic rst,
  input logic rx_tick,
  input logic line_s,
  input logic rx_enable,
  input logic data_ack,
  input logic err_clear,
  input logic frame_done,
  input logic perr_set,
  input logic rx_ready,
  input logic parity_err,
  input logic framing_err,
  input logic overrun_err,
  input logic break_det
);

  // R7
  ready_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> rx_ready);

  // R7
  ack_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (data_ack && !frame_done) |=> !rx_ready);

  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rx_ready && !data_ack) |=> overrun_err);

  // R9
  parity_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (parity_err && !err_clear) |=> parity_err);

  // R9
  framing_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (framing_err && !err_clear) |=> framing_err);

  // R9
  parity_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clear && !perr_set) |=> !parity_err);

  // R11
  break_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_enable && rx_tick && line_s) |=> !break_det);

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> (!break_det && !frame_done));

endmodule

bind serial_async_rx rx_async_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_tick     (rx_tick),
  .line_s      (line_s),
  .rx_enable   (rx_enable),
  .data_ack    (data_ack),
  .err_clear   (err_clear),
  .frame_done  (frame_done),
  .perr_set    (perr_set),
  .rx_ready    (rx_ready),
  .parity_err  (parity_err),
  .framing_err (framing_err),
  .overrun_err (overrun_err),
  .break_det   (break_det)
);

// File: tb/tb_serial_async_rx.sv
`timescale 1ns/1ps
module tb_serial_async_rx;

  localparam int TICK_DIV = 4;
  localparam int NVEC     = 8;
  // {baud[1:0], len[1:0], par_en, par_even, par_bad, stop_bad, data[7:0], expected[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'b01, 2'b11, 4'b0000, 8'hA5, 8'hA5},
    {2'b10, 2'b00, 4'b1000, 8'hFF, 8'h1F},
    {2'b10, 2'b10, 4'b1100, 8'h80, 8'h00},
    {2'b11, 2'b01, 4'b1000, 8'h3C, 8'h3C},
    {2'b10, 2'b11, 4'b1110, 8'h5A, 8'h5A},
    {2'b01, 2'b01, 4'b1101, 8'h2B, 8'h2B},
    {2'b11, 2'b11, 4'b0000, 8'hC3, 8'hC3},
    {2'b01, 2'b00, 4'b1000, 8'h0A, 8'h0A}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       rx_enable = 1'b0;
  logic [1:0] baud_sel = 2'b10;
  logic [1:0] len_sel = 2'b11;
  logic       parity_en = 1'b0;
  logic       parity_even = 1'b0;
  logic [1:0] stop_sel = 2'b01;
  logic       data_ack = 1'b0;
  logic       err_clear = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, parity_err, framing_err, overrun_err, break_det;

  int checks = 0;
  int fails  = 0;
  int div    = 0;
  bit ended  = 0;

  serial_async_rx dut (
    .clk(clk), .rst(rst), .rx_tick(rx_tick), .rx_line(rx_line),
    .rx_enable(rx_enable), .baud_sel(baud_sel), .len_sel(len_sel),
    .parity_en(parity_en), .parity_even(parity_even), .stop_sel(stop_sel),
    .data_ack(data_ack), .err_clear(err_clear), .rx_data(rx_data),
    .rx_ready(rx_ready), .parity_err(parity_err), .framing_err(framing_err),
    .overrun_err(overrun_err), .break_det(break_det)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    rx_tick <= (div == TICK_DIV - 1);
    div     <= (div == TICK_DIV - 1) ? 0 : div + 1;
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (rx_tick !== 1'b1);
    end
    #1;
  endtask

  task automatic pulse_ack();
    @(posedge clk); #1 data_ack = 1'b1;
    @(posedge clk); #1 data_ack = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1 err_clear = 1'b1;
    @(posedge clk); #1 err_clear = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic set_mode(input logic [1:0] b, input logic [1:0] l,
                          input logic pe, input logic pev, input logic [1:0] s);
    baud_sel = b; len_sel = l; parity_en = pe; parity_even = pev; stop_sel = s;
    @(posedge clk); @(posedge clk); #1;
  endtask

  function automatic int ovs(input logic [1:0] b);
    return (b == 2'b10) ? 16 : (b == 2'b11) ? 64 : 1;
  endfunction

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pe,
                            input logic pev, input logic pbad, input logic sbad,
                            input int f);
    logic x;
    x = 1'b0;
    rx_line = 1'b0;
    wait_ticks(f);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      x = x ^ d[i];
      wait_ticks(f);
    end
    if (pe) begin
      rx_line = (pev ? x : ~x) ^ pbad;
      wait_ticks(f);
    end
    rx_line = ~sbad;
    wait_ticks(f);
    rx_line = 1'b1;
    wait_ticks(f + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R13 reset state
    chk("R13 data", rx_data, 8'h00);
    chk("R13 flags", {3'b0, rx_ready, parity_err, framing_err, overrun_err, break_det}, 8'h00);

    // R1 line low when the receiver is enabled
    set_mode(2'b01, 2'b00, 1'b0, 1'b0, 2'b01);
    rx_line = 1'b0;
    wait_ticks(3);
    rx_enable = 1'b1;
    wait_ticks(5);
    rx_line = 1'b1;
    wait_ticks(20);
    chk("R1 no frame from initial low", {7'b0, rx_ready}, 8'h00);

    // Table of formats: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] e;
      e = VEC[v];
      set_mode(e[23:22], e[21:20], e[19], e[18], 2'b01);
      pulse_clear();
      send_frame(e[15:8], 5 + int'(e[21:20]), e[19], e[18], e[17], e[16], ovs(e[23:22]));
      chk("R2/R4 data", rx_data, e[7:0]);
      chk("R7 ready set", {7'b0, rx_ready}, 8'h01);
      chk("R5 parity flag", {7'b0, parity_err}, {7'b0, e[19] & e[17]});
      chk("R6 framing flag", {7'b0, framing_err}, {7'b0, e[16]});
      chk("R8 no overrun", {7'b0, overrun_err}, 8'h00);
      pulse_ack();
      chk("R7 ready cleared", {7'b0, rx_ready}, 8'h00);
    end
    pulse_clear();

    // R3 false start at 16x, then a clean frame
    set_mode(2'b10, 2'b11, 1'b0, 1'b0, 2'b01);
    rx_line = 1'b0;
    wait_ticks(4);
    rx_line = 1'b1;
    wait_ticks(40);
    chk("R3 false start dropped", {7'b0, rx_ready}, 8'h00);
    send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    chk("R3 recovery data", rx_data, 8'h96);
    pulse_ack();

    // R8 overrun: second character replaces the first
    send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    chk("R8 overrun set", {7'b0, overrun_err}, 8'h01);
    chk("R8 data replaced", rx_data, 8'h22);
    pulse_clear();
    chk("R9 overrun cleared", {7'b0, overrun_err}, 8'h00);
    pulse_ack();

    // R9 sticky parity error, reception continues
    set_mode(2'b10, 2'b11, 1'b1, 1'b1, 2'b01);
    send_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1, 1'b0, 16);
    pulse_ack();
    send_frame(8'h33, 8, 1'b1, 1'b1, 1'b0, 1'b0, 16);
    chk("R9 parity flag held", {7'b0, parity_err}, 8'h01);
    chk("R9 receiver still runs", rx_data, 8'h33);
    pulse_clear();
    chk("R9 parity flag cleared", {7'b0, parity_err}, 8'h00);
    pulse_ack();

    // R10 break at 1x, 5 bits + parity, 2 stop bits: 18 strobes
    set_mode(2'b01, 2'b00, 1'b1, 1'b0, 2'b11);
    rx_line = 1'b0;
    wait_ticks(17);
    chk("R10 break one short", {7'b0, break_det}, 8'h00);
    wait_ticks(1);
    chk("R10 break at limit", {7'b0, break_det}, 8'h01);
    rx_line = 1'b1;
    wait_ticks(1);
    chk("R11 break released", {7'b0, break_det}, 8'h00);
    wait_ticks(4);
    pulse_ack();
    pulse_clear();

    // R10 break at 16x, 8 bits, 1.5 stop bits: 336 strobes
    set_mode(2'b10, 2'b11, 1'b0, 1'b0, 2'b10);
    rx_line = 1'b0;
    wait_ticks(335);
    chk("R10 break 16x one short", {7'b0, break_det}, 8'h00);
    wait_ticks(1);
    chk("R10 break 16x at limit", {7'b0, break_det}, 8'h01);
    // R12 disable clears break
    rx_enable = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R12 break cleared by disable", {7'b0, break_det}, 8'h00);
    rx_line = 1'b1;
    wait_ticks(2);
    rx_enable = 1'b1;
    wait_ticks(2);
    pulse_ack();
    pulse_clear();

    // R12 disable in mid frame drops it
    set_mode(2'b10, 2'b11, 1'b0, 1'b0, 2'b01);
    rx_line = 1'b0;
    wait_ticks(16);
    rx_line = 1'b1;
    wait_ticks(16);
    rx_enable = 1'b0;
    rx_line = 1'b0;
    wait_ticks(16 * 9);
    rx_line = 1'b1;
    wait_ticks(2);
    rx_enable = 1'b1;
    wait_ticks(4);
    chk("R12 dropped frame", {7'b0, rx_ready}, 8'h00);
    send_frame(8'h7E, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    chk("R12 receive after re-enable", rx_data, 8'h7E);

    finish_run();
  end

endmodule